// File: doc/BRIEF.md
# Wait and Stop Power-Mode Controller

This block sequences the two sleep depths of a small microcontroller core. The decoded instruction stage hands it a one-cycle strobe for the wait and stop instructions, together with the interrupt-mask flags, the stop-disable flag and the watchdog-off flag. The controller then decides which clocks keep running. It drives clock-gate enables for the CPU, the free-running timer and four peripheral paths (SPI, serial transmit, serial receive, A/D power), an enable for the crystal oscillator, and a one-cycle wake strobe back to the CPU.

In the shallow sleep the CPU is gated, the oscillator keeps running, and the bus is steered to re-read the address where the status register was stacked. Any unmasked interrupt, or the reset pin, ends this sleep. In the deep sleep every clock stops, the oscillator included. A low level on either external interrupt line, a pending latched IRQ edge, or the reset pin restarts the oscillator asynchronously. The controller then waits a fixed settling count before it ungates the CPU. A flag tells the CPU whether the wake came from reset, so that it runs a reset sequence instead of resuming.

Top module: `pmc_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the controller is awake: `cpu_clk_en`, `tmr_clk_en` and `osc_en` are 1, `bus_hold` and `wake_stb` are 0, and `bus_addr` equals `cpu_addr`.
- R2: A `wait_stb` pulse in the awake state enters the shallow sleep at the next clock edge. There `cpu_clk_en` is 0, `osc_en` is 1, `bus_hold` is 1 and `bus_addr` equals `stack_addr`.
- R3: In the shallow sleep, `tmr_clk_en` is 0 exactly when `i_mask` and `cop_off` are both 1, and 1 otherwise.
- R4: The shallow sleep ends, with `cpu_clk_en` back to 1, under any of these conditions: `irq_n` low, `irq_edge_pend` high or `int_req` high while `i_mask` is 0; `xirq_n` low while `x_mask` is 0; `rst_pin_n` low regardless of masks. The external lines and the edge flag go through two synchronizer flops, so the wake appears three clock edges after they change. `int_req` is synchronous and wakes at the next edge. A masked request does not wake the block.
- R5: A `stop_stb` pulse in the awake state enters the deep sleep when `s_dis` is 0. When `s_dis` is 1 the pulse has no effect, and a `wait_stb` pulsed together with it still enters the shallow sleep. If both strobes arrive with `s_dis` 0, the deep sleep wins.
- R6: In the deep sleep `osc_en`, `cpu_clk_en`, `tmr_clk_en` and all four peripheral enables are 0.
- R7: In the deep sleep, `irq_n` low, `xirq_n` low, `irq_edge_pend` high or `rst_pin_n` low raises `osc_en` combinationally, without a clock and regardless of `i_mask` and `x_mask`.
- R8: After a deep-sleep wake source appears, `cpu_clk_en` returns to 1 exactly RESTART_CYC+3 clock edges later: two synchronizer edges, one edge to leave the sleep, and RESTART_CYC settling cycles with the oscillator on and the CPU gated.
- R9: `wake_stb` is 1 for exactly one cycle, the first awake cycle after either sleep. `wake_by_reset` is 1 in that same cycle exactly when the reset pin was the source of the wake.
- R10: In the awake state and in the shallow sleep, `spi_clk_en`, `sctx_clk_en`, `scrx_clk_en` and `adc_clk_en` equal `spi_on`, `sctx_on`, `scrx_on` and `adc_on` respectively.
- R11: A strobe that arrives while the controller is asleep or settling is ignored. A `stop_stb` in the shallow sleep leaves `bus_hold` at 1, and a `wait_stb` in the deep sleep leaves `osc_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock of the controller |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| wait_stb | input | 1 | One-cycle strobe from the decoded wait instruction |
| stop_stb | input | 1 | One-cycle strobe from the decoded stop instruction |
| s_dis | input | 1 | Stop-disable flag; 1 turns stop into a no-op |
| i_mask | input | 1 | Maskable-interrupt mask flag |
| x_mask | input | 1 | Mask flag for the second external interrupt line |
| cop_off | input | 1 | Watchdog-disabled flag |
| spi_on | input | 1 | SPI enable bit |
| sctx_on | input | 1 | Serial transmitter enable bit |
| scrx_on | input | 1 | Serial receiver enable bit |
| adc_on | input | 1 | A/D converter power bit |
| irq_n | input | 1 | Asynchronous maskable interrupt line, active low |
| xirq_n | input | 1 | Asynchronous second interrupt line, active low |
| rst_pin_n | input | 1 | Asynchronous external reset pin, active low |
| irq_edge_pend | input | 1 | Latched pending edge on the maskable interrupt line |
| int_req | input | 1 | Synchronous OR of internal peripheral interrupt requests |
| cpu_addr | input | AW | Address driven by the CPU |
| stack_addr | input | AW | Address where the status register was stacked |
| cpu_clk_en | output | 1 | CPU clock-gate enable |
| tmr_clk_en | output | 1 | Free-running timer clock-gate enable |
| spi_clk_en | output | 1 | SPI clock-gate enable |
| sctx_clk_en | output | 1 | Serial transmitter clock-gate enable |
| scrx_clk_en | output | 1 | Serial receiver clock-gate enable |
| adc_clk_en | output | 1 | A/D converter power/clock enable |
| osc_en | output | 1 | Crystal oscillator run enable |
| wake_stb | output | 1 | One-cycle wake pulse to the CPU |
| wake_by_reset | output | 1 | Qualifies `wake_stb`: the wake came from the reset pin |
| bus_hold | output | 1 | The address override is active |
| bus_addr | output | AW | Address presented to the bus |

## Verification
The shallow-sleep wake logic is tried with every one of the five request sources against all four combinations of the two mask flags. This separates the sources that the maskable flag blocks, the one the second mask blocks, and the reset pin that ignores both. The timer gate is swept over all four mask and watchdog combinations, and the peripheral enables over all sixteen bit patterns in both the awake and the shallow state. The deep sleep is entered with both masks set and woken by each of its four sources in turn. Each run checks the asynchronous oscillator restart, the exact settling count and the reset qualifier, so the level path and the timed path are tested apart from each other.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_RUN     = 2'd0,
    PM_WAIT    = 2'd1,
    PM_STOP    = 2'd2,
    PM_RESTART = 2'd3
  } pm_state_e;

  // Layout of the synchronized request vector (active high)
  localparam int REQ_W   = 5;
  localparam int RQ_IRQ  = 0;
  localparam int RQ_XIRQ = 1;
  localparam int RQ_RST  = 2;
  localparam int RQ_EDGE = 3;
  localparam int RQ_ANY  = 4;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage1_q[g] <= 1'b0;
          stage2_q[g] <= 1'b0;
        end else begin
          stage1_q[g] <= d_async[g];
          stage2_q[g] <= stage1_q[g];
        end
      end
    end
  endgenerate

  assign q_sync = stage2_q;

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int RESTART_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_stb,
  input  logic             stop_stb,
  input  logic             s_dis,
  input  logic             i_mask,
  input  logic             x_mask,
  input  logic             int_req,
  input  logic [REQ_W-1:0] req_s,
  output pm_state_e        state,
  output logic             wake_stb,
  output logic             wake_by_reset
);

  localparam int CW = (RESTART_CYC < 2) ? 1 : $clog2(RESTART_CYC);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RESTART_CYC - 1);

  pm_state_e   state_q, state_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic        cnt_en;
  logic        cause_q, cause_nx;
  logic        wake_q, wake_nx;
  logic        byrst_q, byrst_nx;
  logic        wait_wake;
  logic        stop_wake;

  // Qualified wake for the shallow sleep: reset pin always, XIRQ by its
  // own mask, everything else by the maskable flag.
  assign wait_wake = req_s[RQ_RST]
                   | (req_s[RQ_XIRQ] & ~x_mask)
                   | (~i_mask & (req_s[RQ_IRQ] | req_s[RQ_EDGE] | int_req));
  assign stop_wake = req_s[RQ_ANY];

  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q;
    cnt_en   = 1'b0;
    cause_nx = cause_q;
    wake_nx  = 1'b0;
    byrst_nx = 1'b0;
    case (state_q)
      PM_RUN: begin
        if (stop_stb && !s_dis) begin
          state_nx = PM_STOP;
        end else if (wait_stb) begin
          state_nx = PM_WAIT;
        end
      end
      PM_WAIT: begin
        if (wait_wake) begin
          state_nx = PM_RUN;
          wake_nx  = 1'b1;
          byrst_nx = req_s[RQ_RST];
        end
      end
      PM_STOP: begin
        if (stop_wake) begin
          state_nx = PM_RESTART;
          cnt_nx   = CNT_LOAD;
          cnt_en   = 1'b1;
          cause_nx = req_s[RQ_RST];
        end
      end
      PM_RESTART: begin
        if (cnt_q == '0) begin
          state_nx = PM_RUN;
          wake_nx  = 1'b1;
          byrst_nx = cause_q;
        end else begin
          cnt_nx = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_nx = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      cause_q <= 1'b0;
      wake_q  <= 1'b0;
      byrst_q <= 1'b0;
    end else begin
      state_q <= state_nx;
      cause_q <= cause_nx;
      wake_q  <= wake_nx;
      byrst_q <= byrst_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nx;
    end
  end

  assign state         = state_q;
  assign wake_stb      = wake_q;
  assign wake_by_reset = byrst_q;

  AST_STOP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && stop_stb && s_dis && !wait_stb) |=> (state_q == PM_RUN)); // R5
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q); // R9
  AST_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (state_q == PM_RUN)); // R9
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_STOP && !req_s[RQ_ANY]) |=> (state_q == PM_STOP)); // R7
  AST_STOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_STOP) |=> (state_q == PM_STOP || state_q == PM_RESTART)); // R11
  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_WAIT) |=> (state_q == PM_WAIT || state_q == PM_RUN)); // R11

endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
  import pmc_pkg::*;
(
  input  pm_state_e state,
  input  logic      i_mask,
  input  logic      cop_off,
  input  logic      spi_on,
  input  logic      sctx_on,
  input  logic      scrx_on,
  input  logic      adc_on,
  input  logic      wake_async,
  output logic      cpu_clk_en,
  output logic      tmr_clk_en,
  output logic      spi_clk_en,
  output logic      sctx_clk_en,
  output logic      scrx_clk_en,
  output logic      adc_clk_en,
  output logic      osc_en
);

  logic periph_ok;

  always_comb begin
    cpu_clk_en = 1'b0;
    tmr_clk_en = 1'b0;
    periph_ok  = 1'b0;
    case (state)
      PM_RUN: begin
        cpu_clk_en = 1'b1;
        tmr_clk_en = 1'b1;
        periph_ok  = 1'b1;
      end
      PM_WAIT: begin
        tmr_clk_en = ~(i_mask & cop_off);
        periph_ok  = 1'b1;
      end
      default: begin
        cpu_clk_en = 1'b0;
      end
    endcase
  end

  assign spi_clk_en  = periph_ok & spi_on;
  assign sctx_clk_en = periph_ok & sctx_on;
  assign scrx_clk_en = periph_ok & scrx_on;
  assign adc_clk_en  = periph_ok & adc_on;

  // Oscillator restart needs no clock: the raw wake level feeds it directly.
  assign osc_en = (state != PM_STOP) | wake_async;

endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int AW          = 16,
  parameter int RESTART_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_stb,
  input  logic          stop_stb,
  input  logic          s_dis,
  input  logic          i_mask,
  input  logic          x_mask,
  input  logic          cop_off,
  input  logic          spi_on,
  input  logic          sctx_on,
  input  logic          scrx_on,
  input  logic          adc_on,
  input  logic          irq_n,
  input  logic          xirq_n,
  input  logic          rst_pin_n,
  input  logic          irq_edge_pend,
  input  logic          int_req,
  input  logic [AW-1:0] cpu_addr,
  input  logic [AW-1:0] stack_addr,
  output logic          cpu_clk_en,
  output logic          tmr_clk_en,
  output logic          spi_clk_en,
  output logic          sctx_clk_en,
  output logic          scrx_clk_en,
  output logic          adc_clk_en,
  output logic          osc_en,
  output logic          wake_stb,
  output logic          wake_by_reset,
  output logic          bus_hold,
  output logic [AW-1:0] bus_addr
);

  logic             wake_async;
  logic [REQ_W-1:0] req_raw;
  logic [REQ_W-1:0] req_s;
  pm_state_e        state;

  assign wake_async = ~irq_n | ~xirq_n | ~rst_pin_n | irq_edge_pend;

  assign req_raw[RQ_IRQ]  = ~irq_n;
  assign req_raw[RQ_XIRQ] = ~xirq_n;
  assign req_raw[RQ_RST]  = ~rst_pin_n;
  assign req_raw[RQ_EDGE] = irq_edge_pend;
  assign req_raw[RQ_ANY]  = wake_async;

  pmc_sync #(.W(REQ_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (req_raw),
    .q_sync  (req_s)
  );

  pmc_fsm #(.RESTART_CYC(RESTART_CYC)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .wait_stb      (wait_stb),
    .stop_stb      (stop_stb),
    .s_dis         (s_dis),
    .i_mask        (i_mask),
    .x_mask        (x_mask),
    .int_req       (int_req),
    .req_s         (req_s),
    .state         (state),
    .wake_stb      (wake_stb),
    .wake_by_reset (wake_by_reset)
  );

  pmc_gate u_gate (
    .state       (state),
    .i_mask      (i_mask),
    .cop_off     (cop_off),
    .spi_on      (spi_on),
    .sctx_on     (sctx_on),
    .scrx_on     (scrx_on),
    .adc_on      (adc_on),
    .wake_async  (wake_async),
    .cpu_clk_en  (cpu_clk_en),
    .tmr_clk_en  (tmr_clk_en),
    .spi_clk_en  (spi_clk_en),
    .sctx_clk_en (sctx_clk_en),
    .scrx_clk_en (scrx_clk_en),
    .adc_clk_en  (adc_clk_en),
    .osc_en      (osc_en)
  );

  assign bus_hold = (state == PM_WAIT);
  assign bus_addr = bus_hold ? stack_addr : cpu_addr;

  AST_WAIT_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hold |-> (osc_en && !cpu_clk_en)); // R2
  AST_TMR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hold && i_mask && cop_off) |-> !tmr_clk_en); // R3
  AST_DARK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !(cpu_clk_en || tmr_clk_en || spi_clk_en || sctx_clk_en
                  || scrx_clk_en || adc_clk_en)); // R6
  AST_WAKE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb |-> (cpu_clk_en && osc_en && !bus_hold)); // R9

endmodule

// File: tb/pmc_top_test.sv
module pmc_top_test;

  localparam int AW = 12;
  localparam int NR = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic wait_stb, stop_stb, s_dis, i_mask, x_mask, cop_off;
  logic spi_on, sctx_on, scrx_on, adc_on;
  logic irq_n, xirq_n, rst_pin_n, irq_edge_pend, int_req;
  logic [AW-1:0] cpu_addr, stack_addr;
  logic cpu_clk_en, tmr_clk_en, spi_clk_en, sctx_clk_en, scrx_clk_en, adc_clk_en;
  logic osc_en, wake_stb, wake_by_reset, bus_hold;
  logic [AW-1:0] bus_addr;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pmc_top #(.AW(AW), .RESTART_CYC(NR)) uut (
    .clk(clk), .rst_n(rst_n), .wait_stb(wait_stb), .stop_stb(stop_stb),
    .s_dis(s_dis), .i_mask(i_mask), .x_mask(x_mask), .cop_off(cop_off),
    .spi_on(spi_on), .sctx_on(sctx_on), .scrx_on(scrx_on), .adc_on(adc_on),
    .irq_n(irq_n), .xirq_n(xirq_n), .rst_pin_n(rst_pin_n),
    .irq_edge_pend(irq_edge_pend), .int_req(int_req),
    .cpu_addr(cpu_addr), .stack_addr(stack_addr),
    .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en), .spi_clk_en(spi_clk_en),
    .sctx_clk_en(sctx_clk_en), .scrx_clk_en(scrx_clk_en), .adc_clk_en(adc_clk_en),
    .osc_en(osc_en), .wake_stb(wake_stb), .wake_by_reset(wake_by_reset),
    .bus_hold(bus_hold), .bus_addr(bus_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic w, input logic s);
    @(negedge clk);
    wait_stb = w;
    stop_stb = s;
    @(negedge clk);
    wait_stb = 1'b0;
    stop_stb = 1'b0;
  endtask

  task automatic count_run(input int lim, output int n);
    n = 0;
    while (!cpu_clk_en && n < lim) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  // Set source k active: 0 irq, 1 xirq, 2 internal, 3 edge, 4 reset pin
  task automatic drive_src(input int k, input logic on);
    case (k)
      0: irq_n = ~on;
      1: xirq_n = ~on;
      2: int_req = on;
      3: irq_edge_pend = on;
      default: rst_pin_n = ~on;
    endcase
  endtask

  task automatic exit_by_reset_pin();
    int n;
    rst_pin_n = 1'b0;
    count_run(12, n);
    rst_pin_n = 1'b1;
    idle(4);
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    wait_stb = 0; stop_stb = 0; s_dis = 0; i_mask = 0; x_mask = 0; cop_off = 0;
    spi_on = 1; sctx_on = 0; scrx_on = 1; adc_on = 0;
    irq_n = 1; xirq_n = 1; rst_pin_n = 1; irq_edge_pend = 0; int_req = 0;
    cpu_addr = 12'h3A5; stack_addr = 12'h0F7;
    idle(2);
    // R1: reset state
    check("R1 cpu_en", cpu_clk_en, 1);
    check("R1 osc_en", osc_en, 1);
    check("R1 tmr_en", tmr_clk_en, 1);
    check("R1 hold", bus_hold, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wake_stb", wake_stb, 0);
    check("R1 bus_addr", bus_addr, 12'h3A5);

    // R2 and R3: timer gate sweep over mask and watchdog flags
    for (int c = 0; c < 4; c++) begin
      i_mask = c[0];
      cop_off = c[1];
      pulse(1'b1, 1'b0);
      check("R2 cpu_off", cpu_clk_en, 0);
      check("R2 osc_on", osc_en, 1);
      check("R2 hold", bus_hold, 1);
      check("R2 addr", bus_addr, 12'h0F7);
      check("R3 tmr", tmr_clk_en, (c == 3) ? 0 : 1);
      exit_by_reset_pin();
    end
    cop_off = 0;

    // R10: peripheral enables in run and in wait
    for (int p = 0; p < 16; p++) begin
      {adc_on, scrx_on, sctx_on, spi_on} = 4'(p);
      @(negedge clk);
      check("R10 run", {adc_clk_en, scrx_clk_en, sctx_clk_en, spi_clk_en}, p);
      pulse(1'b1, 1'b0);
      check("R10 wait", {adc_clk_en, scrx_clk_en, sctx_clk_en, spi_clk_en}, p);
      exit_by_reset_pin();
    end
    spi_on = 1; sctx_on = 1; scrx_on = 1; adc_on = 1;

    // R4, R9: wait wake qualification, all sources against all masks
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 5; k++) begin
        logic expw;
        i_mask = m[0];
        x_mask = m[1];
        expw = (k == 4) || (k == 1 && !m[1]) || (k != 1 && k != 4 && !m[0]);
        pulse(1'b1, 1'b0);
        drive_src(k, 1'b1);
        count_run(8, n);
        if (expw) begin
          check("R4 wake latency", n, (k == 2) ? 1 : 3);
          check("R9 wake_stb", wake_stb, 1);
          check("R9 by_reset", wake_by_reset, (k == 4) ? 1 : 0);
          drive_src(k, 1'b0);
          @(negedge clk);
          check("R9 single pulse", wake_stb, 0);
          idle(4);
        end else begin
          check("R4 masked no wake", bus_hold, 1);
          drive_src(k, 1'b0);
          exit_by_reset_pin();
        end
      end
    end

    // R11: stop strobe during wait ignored
    i_mask = 0; x_mask = 0;
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    check("R11 wait keeps", bus_hold, 1);
    check("R11 wait osc", osc_en, 1);
    exit_by_reset_pin();

    // R5: stop disabled is a no-op, wait still taken with it
    s_dis = 1;
    pulse(1'b0, 1'b1);
    check("R5 nop cpu", cpu_clk_en, 1);
    check("R5 nop osc", osc_en, 1);
    check("R5 nop hold", bus_hold, 0);
    pulse(1'b1, 1'b1);
    check("R5 wait taken", bus_hold, 1);
    exit_by_reset_pin();
    s_dis = 0;
    // R5: both strobes with stop allowed: deep sleep
    pulse(1'b1, 1'b1);
    check("R5 stop wins", osc_en, 0);
    check("R5 stop hold", bus_hold, 0);
    exit_by_reset_pin();

    // R6, R7, R8, R9, R11: deep sleep with each wake source, masks set
    for (int k = 0; k < 5; k++) begin
      if (k == 2) continue;
      i_mask = 1; x_mask = 1;
      pulse(1'b0, 1'b1);
      check("R6 osc off", osc_en, 0);
      check("R6 all off", {cpu_clk_en, tmr_clk_en, spi_clk_en, sctx_clk_en,
                           scrx_clk_en, adc_clk_en}, 0);
      pulse(1'b1, 1'b0);
      check("R11 stop keeps", osc_en, 0);
      drive_src(k, 1'b1);
      #1;
      check("R7 async osc", osc_en, 1);
      count_run(20, n);
      check("R8 restart count", n, NR + 3);
      check("R9 stop wake_stb", wake_stb, 1);
      check("R9 stop by_reset", wake_by_reset, (k == 4) ? 1 : 0);
      drive_src(k, 1'b0);
      @(negedge clk);
      check("R9 stop single", wake_stb, 0);
      idle(4);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule